// File: doc/BRIEF.md
# Exponential Moving Average Utilization Predictor

This block watches a processor's busy signal and turns each measurement interval into a load figure. An external strobe marks the last cycle of every interval. The busy cycles counted in that interval are scaled against the programmed interval length to give an 8-bit run-percent, where 255 stands for fully busy.

That run-percent is then folded into a stored running average with a programmable weight on history: new = floor((weight × old + run-percent) / (weight + 1)). The result is the prediction for the next interval. One shared sequential restoring divider does both the scaling and the averaging. When weight + 1 is a power of two, a parameter lets the averaging step use a shift in place of the divider.

Two threshold inputs are compared against the prediction. The compare gives a speed-up request and a slow-down request, which a speed-level controller can use.

Top module: `util_ema_pred`

## Requirements
- R1: While reset is applied and after it is released, the prediction and run-percent are 0 and the valid strobe is low.
- R2: The busy count is the number of cycles with `busy_i` high from the cycle after the previous strobe up to and including the current strobe cycle. The count saturates at its maximum and restarts after every strobe.
- R3: Run-percent = floor(count × 255 / L), capped at 255. L is `ivl_len_i` sampled on the strobe cycle. When L = 0 the run-percent is 0.
- R4: The prediction becomes floor((W × old + run-percent) / (W + 1)). W is `weight_i` (0 to 7) sampled on the strobe cycle. W = 0 makes the prediction equal the run-percent.
- R5: Each accepted strobe produces exactly one single-cycle pulse on `pred_vld_o`. By the time of that pulse both `run_pct_o` and `pred_o` hold their new values. `pred_o` changes only in a cycle in which `pred_vld_o` is high.
- R6: Each new prediction lies between the previous prediction and the new run-percent, inclusive.
- R7: A strobe that arrives while an update is in progress adds no sample, produces no valid pulse and leaves the prediction unchanged. The busy count still restarts after it.
- R8: `speed_up_o` is high exactly when the prediction exceeds `up_thr_i`. `slow_down_o` is high exactly when the prediction is below `dn_thr_i`. Both follow threshold changes with no register delay.
- R9: Weights for which W + 1 is a power of two (0, 1, 3, 7) give the same prediction as the divider path used for all other weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Processor busy in this cycle |
| ivl_end_i | input | 1 | Last cycle of the measurement interval |
| ivl_len_i | input | CNT_W | Interval length in cycles, used for scaling |
| weight_i | input | WGT_W | History weight W |
| up_thr_i | input | PCT_W | Speed-up threshold |
| dn_thr_i | input | PCT_W | Slow-down threshold |
| run_pct_o | output | PCT_W | Run-percent of the last accepted interval |
| pred_o | output | PCT_W | Predicted utilization |
| pred_vld_o | output | 1 | One-cycle pulse when a new prediction is ready |
| speed_up_o | output | 1 | Prediction above the speed-up threshold |
| slow_down_o | output | 1 | Prediction below the slow-down threshold |

## Verification
Some properties are checked on every cycle. These are:
- the valid pulse and the divider's completion pulse each last a single cycle;
- the prediction never moves outside a valid pulse;
- each new average stays between the old average and the fresh sample;
- the busy count is zero right after any strobe;
- both requests are never raised together when the thresholds are ordered.

The exact arithmetic can only be shown by the bench scenarios, because it depends on the history of samples. That covers floor rounding, the cap, the zero-length case, the weight-0 case, and agreement between the shift path and the divider path. The bench's scenarios are also the only place where a strobe dropped during an update is shown not to leak into the next interval's count.

// File: rtl/uep_pkg.sv
package uep_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PCT_GO,
      ST_PCT_WAIT,
      ST_AVG_GO,
      ST_AVG_WAIT,
      ST_OUT
   } uep_state_e;
endpackage

// File: rtl/uep_busy_cnt.sv
module uep_busy_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] snap_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   // Count including the current cycle, saturating at the top.
   always_comb begin
      if (busy_i && cnt_q != CNT_MAX) snap_o = cnt_q + CNT_W'(1);
      else                            snap_o = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= snap_o;
   end

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/uep_divider.sv
module uep_divider #(
   parameter int NUM_W = 24,
   parameter int DEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             done_o,
   output logic [NUM_W-1:0] quot_o
);
   localparam int ITR_W = $clog2(NUM_W + 1);

   logic [DEN_W-1:0] rem_q, den_q;
   logic [NUM_W-1:0] quo_q;
   logic [ITR_W-1:0] itr_q;
   logic             run_q, done_q;
   logic [DEN_W:0]   shf;
   logic             fits;

   always_comb begin
      shf  = {rem_q, quo_q[NUM_W-1]};
      fits = (shf >= {1'b0, den_q});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         den_q  <= '0;
         quo_q  <= '0;
         itr_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (start_i) begin
         rem_q  <= '0;
         den_q  <= den_i;
         quo_q  <= num_i;
         itr_q  <= ITR_W'(NUM_W);
         run_q  <= 1'b1;
         done_q <= 1'b0;
      end else if (run_q) begin
         if (fits) begin
            rem_q <= DEN_W'(shf - {1'b0, den_q});
            quo_q <= {quo_q[NUM_W-2:0], 1'b1};
         end else begin
            rem_q <= DEN_W'(shf);
            quo_q <= {quo_q[NUM_W-2:0], 1'b0};
         end
         itr_q <= itr_q - ITR_W'(1);
         if (itr_q == ITR_W'(1)) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
         end
      end else begin
         done_q <= 1'b0;
      end
   end

   assign done_o = done_q;
   assign quot_o = quo_q;

   AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R5
endmodule

// File: rtl/util_ema_pred.sv
module util_ema_pred
   import uep_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int PCT_W     = 8,
   parameter int WGT_W     = 3,
   parameter bit USE_SHIFT = 1'b1,
   parameter bit USE_THR   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy_i,
   input  logic             ivl_end_i,
   input  logic [CNT_W-1:0] ivl_len_i,
   input  logic [WGT_W-1:0] weight_i,
   input  logic [PCT_W-1:0] up_thr_i,
   input  logic [PCT_W-1:0] dn_thr_i,
   output logic [PCT_W-1:0] run_pct_o,
   output logic [PCT_W-1:0] pred_o,
   output logic             pred_vld_o,
   output logic             speed_up_o,
   output logic             slow_down_o
);
   localparam int NUM_W = CNT_W + PCT_W;
   localparam int SUM_W = PCT_W + WGT_W;
   localparam logic [NUM_W-1:0] FULL_N = NUM_W'((1 << PCT_W) - 1);

   if (CNT_W < WGT_W + 2) begin : g_bad_cnt
      $error("CNT_W too narrow for the weight divisor");
   end
   if (PCT_W < 2 || WGT_W < 1) begin : g_bad_pct
      $error("PCT_W or WGT_W out of range");
   end

   uep_state_e       state_q;
   logic [CNT_W-1:0] snap, smp_q, len_q;
   logic [WGT_W-1:0] wgt_q;
   logic [PCT_W-1:0] pct_q, pred_q;
   logic [SUM_W-1:0] sum;
   logic [NUM_W-1:0] div_num, div_quot;
   logic [CNT_W-1:0] div_den;
   logic             div_start, div_done;
   logic             shift_hit;
   logic [SUM_W-1:0] shift_res;

   function automatic logic [PCT_W-1:0] clip(input logic [NUM_W-1:0] v);
      return (v > FULL_N) ? PCT_W'(FULL_N) : PCT_W'(v);
   endfunction

   uep_busy_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (busy_i),
      .clr_i  (ivl_end_i),
      .snap_o (snap)
   );

   always_comb sum = SUM_W'(wgt_q) * SUM_W'(pred_q) + SUM_W'(pct_q);

   // Fast path for weights whose divisor is a power of two.
   if (USE_SHIFT) begin : g_shift
      always_comb begin
         shift_hit = ((wgt_q & (wgt_q + WGT_W'(1))) == '0);
         shift_res = sum >> $countones(wgt_q);
      end
   end else begin : g_noshift
      always_comb begin
         shift_hit = 1'b0;
         shift_res = '0;
      end
   end

   always_comb begin
      if (state_q == ST_PCT_GO) begin
         div_num = NUM_W'(smp_q) * FULL_N;
         div_den = len_q;
      end else begin
         div_num = NUM_W'(sum);
         div_den = CNT_W'(wgt_q) + CNT_W'(1);
      end
      div_start = ((state_q == ST_PCT_GO) && (len_q != '0)) ||
                  ((state_q == ST_AVG_GO) && !shift_hit);
   end

   uep_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (div_start),
      .num_i   (div_num),
      .den_i   (div_den),
      .done_o  (div_done),
      .quot_o  (div_quot)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         smp_q   <= '0;
         len_q   <= '0;
         wgt_q   <= '0;
         pct_q   <= '0;
         pred_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (ivl_end_i) begin
               smp_q   <= snap;
               len_q   <= ivl_len_i;
               wgt_q   <= weight_i;
               state_q <= ST_PCT_GO;
            end
            ST_PCT_GO: if (len_q == '0) begin
               pct_q   <= '0;
               state_q <= ST_AVG_GO;
            end else begin
               state_q <= ST_PCT_WAIT;
            end
            ST_PCT_WAIT: if (div_done) begin
               pct_q   <= clip(div_quot);
               state_q <= ST_AVG_GO;
            end
            ST_AVG_GO: if (shift_hit) begin
               pred_q  <= clip(NUM_W'(shift_res));
               state_q <= ST_OUT;
            end else begin
               state_q <= ST_AVG_WAIT;
            end
            ST_AVG_WAIT: if (div_done) begin
               pred_q  <= clip(div_quot);
               state_q <= ST_OUT;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign run_pct_o  = pct_q;
   assign pred_o     = pred_q;
   assign pred_vld_o = (state_q == ST_OUT);

   if (USE_THR) begin : g_thr
      assign speed_up_o  = (pred_q > up_thr_i);
      assign slow_down_o = (pred_q < dn_thr_i);
   end else begin : g_nothr
      assign speed_up_o  = 1'b0;
      assign slow_down_o = 1'b0;
   end

   AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pred_vld_o |=> !pred_vld_o); // R5
   AST_PRED_ONLY_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_q != $past(pred_q)) |-> pred_vld_o); // R5
   AST_PRED_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      pred_vld_o |-> (((pred_q >= $past(pred_q)) || (pred_q >= pct_q)) &&
                      ((pred_q <= $past(pred_q)) || (pred_q <= pct_q)))); // R6
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (up_thr_i >= dn_thr_i) |-> !(speed_up_o && slow_down_o)); // R8
endmodule

// File: tb/sim_util_ema_pred.sv
module sim_util_ema_pred;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        busy, ivl_end;
   logic [15:0] ivl_len;
   logic [2:0]  weight;
   logic [7:0]  up_thr, dn_thr;
   logic [7:0]  run_pct, pred;
   logic        pred_vld, speed_up, slow_down;

   int checks = 0;
   int errors = 0;
   int model  = 0;

   always #5 clk = ~clk;

   util_ema_pred u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy_i      (busy),
      .ivl_end_i   (ivl_end),
      .ivl_len_i   (ivl_len),
      .weight_i    (weight),
      .up_thr_i    (up_thr),
      .dn_thr_i    (dn_thr),
      .run_pct_o   (run_pct),
      .pred_o      (pred),
      .pred_vld_o  (pred_vld),
      .speed_up_o  (speed_up),
      .slow_down_o (slow_down)
   );

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d exp %0d", tag, got, exp);
      end
   endtask

   function automatic int exp_pct(input int cnt, input int len);
      int v;
      if (len == 0) return 0;
      v = (cnt * 255) / len;
      return (v > 255) ? 255 : v;
   endfunction

   // Drive one interval of ncyc cycles, busy in the first nbusy, strobe on the last.
   task automatic drive_ivl(input int ncyc, input int nbusy);
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         busy    = (i < nbusy);
         ivl_end = (i == ncyc - 1);
      end
      @(negedge clk);
      busy    = 1'b0;
      ivl_end = 1'b0;
   endtask

   task automatic wait_vld(input string tag);
      for (int i = 0; i < 200; i++) begin
         if (pred_vld) return;
         @(negedge clk);
      end
      chk({tag, " valid pulse seen"}, 0, 1);
   endtask

   task automatic run_ivl(input string tag, input int len, input int ncyc,
                          input int nbusy, input int w);
      int p;
      ivl_len = 16'(len);
      weight  = 3'(w);
      drive_ivl(ncyc, nbusy);
      wait_vld(tag);
      p     = exp_pct(nbusy, len);
      model = (w * model + p) / (w + 1);
      chk({tag, " R3 run_pct"}, run_pct, p);
      chk({tag, " R4 pred"}, pred, model);
      @(negedge clk);
      chk({tag, " R5 pulse one cycle"}, pred_vld, 0);
   endtask

   task automatic t_reset;
      chk("R1 pred after reset", pred, 0);
      chk("R1 run_pct after reset", run_pct, 0);
      chk("R1 valid low after reset", pred_vld, 0);
      chk("R8 no flags at reset", {speed_up, slow_down}, 0);
   endtask

   task automatic t_dropped_strobe;
      int nv = 0;
      int p;
      ivl_len = 16'd20;
      weight  = 3'd3;
      drive_ivl(20, 8);
      p     = exp_pct(8, 20);
      model = (3 * model + p) / 4;
      // Second strobe lands while the update is still running.
      busy = 1'b1;
      @(negedge clk);
      @(negedge clk);
      ivl_end = 1'b1;
      @(negedge clk);
      busy    = 1'b0;
      ivl_end = 1'b0;
      for (int i = 0; i < 150; i++) begin
         if (pred_vld) nv++;
         @(negedge clk);
      end
      chk("R7 single pulse for two strobes", nv, 1);
      chk("R7 pred from first sample only", pred, model);
      // Next interval must not contain the busy cycles before the dropped strobe.
      run_ivl("R7 count restarted", 10, 10, 4, 3);
   endtask

   task automatic t_thresh;
      up_thr = 8'd70;
      dn_thr = 8'd20;
      @(negedge clk);
      chk("R8 speed_up above", speed_up, (model > 70) ? 1 : 0);
      chk("R8 slow_down not below", slow_down, (model < 20) ? 1 : 0);
      up_thr = 8'd200;
      dn_thr = 8'd100;
      #1;
      chk("R8 speed_up cleared", speed_up, (model > 200) ? 1 : 0);
      chk("R8 slow_down set", slow_down, (model < 100) ? 1 : 0);
      up_thr = 8'(model);
      dn_thr = 8'(model);
      #1;
      chk("R8 equal to thresholds", {speed_up, slow_down}, 0);
   endtask

   initial begin
      rst_n   = 1'b0;
      busy    = 1'b0;
      ivl_end = 1'b0;
      ivl_len = 16'd0;
      weight  = 3'd3;
      up_thr  = 8'd255;
      dn_thr  = 8'd0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run_ivl("R2 half busy w3", 100, 100, 50, 3);
      run_ivl("R9 full busy w3 shift", 100, 100, 100, 3);
      run_ivl("R4 weight zero", 80, 80, 20, 0);
      run_ivl("R9 weight five divider", 40, 40, 40, 5);
      run_ivl("R3 zero length", 0, 10, 10, 1);
      run_ivl("R3 capped", 5, 20, 20, 7);
      run_ivl("R6 low sample w7", 64, 64, 3, 7);
      t_dropped_strobe();
      t_thresh();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R5 got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule